// File: doc/BRIEF.md
# Branch Condition Resolution Unit

This unit sits in the execute stage of a five-stage in-order pipeline and deals with compare, jump and conditional-branch instructions. Each cycle it may receive one decoded instruction. That instruction carries an operation code, two register operands, a signed offset and the program counter that was recorded when it was fetched. The unit owns the greater-than and equal condition flags, and only a compare instruction writes them. The arithmetic unit drives the underflow and overflow conditions as inputs, and this unit only reads them.

When a control transfer is taken, the unit reports three things in the cycle the instruction leaves execute. It gives a result value. It gives a redirect strobe with a target address reduced modulo the instruction-memory depth. It gives a per-stage squash mask that tells every occupied younger stage to turn its instruction into a NOP. A conditional branch whose flag is clear returns an all-ones marker and requests no redirect.

Top module: `brc_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_vld`, `redir`, `squash_mask`, `flag_gt` and `flag_eq` are all zero.
- R2: Operation codes are: 0 NOP, 1 CMP, 2 JMP, 3 JAL, 4 JRL, 5 BEQ, 6 BGT, 7 BUF, 8 BOF. An accepted CMP rewrites both flags. `flag_gt` is set to (opa > opb) compared as signed values, and `flag_eq` is set to (opa == opb). Both are visible the cycle after the compare.
- R3: The flags keep their values in every cycle without an accepted CMP.
- R4: BEQ, BGT, BUF and BOF test `flag_eq`, `flag_gt`, `alu_uf` and `alu_of` respectively. When the tested condition is set, `res` is wrap(pc + ofs) zero-extended, `redir` is 1 and `redir_pc` is wrap(pc + ofs).
- R5: When the tested condition of a conditional branch is clear, `res` is all ones, `res_vld` is 1, and `redir` and `squash_mask` are 0.
- R6: JRL always redirects. `res` is pc + ofs, not wrapped, at full data width.
- R7: JMP and JAL always redirect. `res` is opa + ofs at full data width.
- R8: The redirect target is the low log2(IMEM_DEPTH) bits of the sum, which is the sum modulo the instruction-memory depth.
- R9: All results appear one cycle after the instruction is presented. `redir` and the squash mask stay high for exactly that one cycle unless the next instruction also redirects.
- R10: On a redirect, bit i of `squash_mask` equals `yng_vld[i]` sampled with the branch. An empty younger stage is never flagged, and the mask is zero when no redirect occurs.
- R11: With `ex_valid` low, or with an operation code from 9 to 15, nothing is produced: `res_vld`, `redir` and `squash_mask` stay 0 and the flags are unchanged.
- R12: The offset is two's complement, so a negative offset gives a backward target. For example, pc 8 with offset -7 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | An instruction is in execute this cycle |
| ex_op | input | 4 | Operation code (see R2) |
| ex_pc | input | PC_W | PC recorded at fetch |
| ex_opa | input | DW | First register operand |
| ex_opb | input | DW | Second register operand (compare only) |
| ex_ofs | input | DW | Signed offset |
| alu_uf | input | 1 | Underflow condition from the arithmetic unit |
| alu_of | input | 1 | Overflow condition from the arithmetic unit |
| yng_vld | input | NYNG | Occupancy of each younger stage |
| res_vld | output | 1 | A control instruction left execute |
| res | output | DW | Target, link sum or not-taken marker |
| redir | output | 1 | One-cycle redirect strobe to fetch |
| redir_pc | output | PC_W | Wrapped redirect target |
| squash_mask | output | NYNG | Per-stage NOP request |
| flag_gt | output | 1 | Greater-than flag |
| flag_eq | output | 1 | Equal flag |

## Verification
The embedded properties assume `ex_valid` and `yng_vld` are known after reset. They also assume that the only path into the flags is a CMP accepted while `ex_valid` is high. The stimulus drives every input away from the rising edge and always from defined values. It runs the table back to back with no idle gap, so consecutive redirects are legal there. Only the directed strobe-length test inserts idle cycles and then expects the strobe to fall.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_CMP = 4'd1,
    OP_JMP = 4'd2,
    OP_JAL = 4'd3,
    OP_JRL = 4'd4,
    OP_BEQ = 4'd5,
    OP_BGT = 4'd6,
    OP_BUF = 4'd7,
    OP_BOF = 4'd8
  } brc_op_e;
endpackage

// File: rtl/brc_flags.sv
module brc_flags #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          gt_q,
  output logic          eq_q
);
  logic gt_d, eq_d;

  always_comb begin
    gt_d = gt_q;
    eq_d = eq_q;
    if (cmp_en) begin
      gt_d = $signed(opa) > $signed(opb);
      eq_d = opa == opb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gt_q <= 1'b0;
      eq_q <= 1'b0;
    end else begin
      gt_q <= gt_d;
      eq_q <= eq_d;
    end
  end

  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable({gt_q, eq_q}));

  assert_gt_eq_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gt_q && eq_q));
endmodule

// File: rtl/brc_target.sv
module brc_target
  import brc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int PC_W = 10
) (
  input  logic [3:0]      op,
  input  logic [PC_W-1:0] pc,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   ofs,
  input  logic            gt,
  input  logic            eq,
  input  logic            uf,
  input  logic            ovf,
  output logic            is_cmp,
  output logic            is_ctl,
  output logic            taken,
  output logic [DW-1:0]   res,
  output logic [PC_W-1:0] tgt
);
  localparam int PADW = DW - PC_W;

  logic [DW-1:0] pc_ext, rel_sum, abs_sum, sel_sum;
  logic          cond;

  assign pc_ext  = {{PADW{1'b0}}, pc};
  assign rel_sum = pc_ext + ofs;
  assign abs_sum = opa + ofs;

  always_comb begin
    is_cmp  = 1'b0;
    is_ctl  = 1'b0;
    taken   = 1'b0;
    cond    = 1'b0;
    sel_sum = rel_sum;
    res     = '0;
    unique case (op)
      OP_CMP: is_cmp = 1'b1;
      OP_JMP, OP_JAL: begin
        is_ctl  = 1'b1;
        taken   = 1'b1;
        sel_sum = abs_sum;
        res     = abs_sum;
      end
      OP_JRL: begin
        is_ctl = 1'b1;
        taken  = 1'b1;
        res    = rel_sum;
      end
      OP_BEQ, OP_BGT, OP_BUF, OP_BOF: begin
        is_ctl = 1'b1;
        case (op)
          OP_BEQ:  cond = eq;
          OP_BGT:  cond = gt;
          OP_BUF:  cond = uf;
          default: cond = ovf;
        endcase
        taken = cond;
        res   = cond ? {{PADW{1'b0}}, rel_sum[PC_W-1:0]} : '1;
      end
      default: ;
    endcase
  end

  assign tgt = sel_sum[PC_W-1:0];
endmodule

// File: rtl/brc_redirect.sv
module brc_redirect #(
  parameter int DW   = 32,
  parameter int PC_W = 10,
  parameter int NYNG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_en,
  input  logic            taken,
  input  logic [DW-1:0]   res_d,
  input  logic [PC_W-1:0] tgt_d,
  input  logic [NYNG-1:0] yng,
  output logic            res_vld_q,
  output logic [DW-1:0]   res_q,
  output logic            redir_q,
  output logic [PC_W-1:0] tgt_q,
  output logic [NYNG-1:0] mask_q
);
  logic            redir_d;
  logic [NYNG-1:0] mask_d;

  assign redir_d = ctl_en && taken;

  for (genvar g = 0; g < NYNG; g++) begin : g_stage
    assign mask_d[g] = redir_d && yng[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_q <= 1'b0;
      redir_q   <= 1'b0;
      mask_q    <= '0;
    end else begin
      res_vld_q <= ctl_en;
      redir_q   <= redir_d;
      mask_q    <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      tgt_q <= '0;
    end else if (ctl_en) begin
      res_q <= res_d;
      tgt_q <= tgt_d;
    end
  end

  assert_mask_needs_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |-> redir_q);

  assert_mask_only_occupied_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((yng & {NYNG{ctl_en}}) == '0) |=> (mask_q == '0));
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int IMEM_DEPTH = 1024,
  parameter int NYNG       = 2,
  parameter int PC_W       = $clog2(IMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic [3:0]      ex_op,
  input  logic [PC_W-1:0] ex_pc,
  input  logic [DW-1:0]   ex_opa,
  input  logic [DW-1:0]   ex_opb,
  input  logic [DW-1:0]   ex_ofs,
  input  logic            alu_uf,
  input  logic            alu_of,
  input  logic [NYNG-1:0] yng_vld,
  output logic            res_vld,
  output logic [DW-1:0]   res,
  output logic            redir,
  output logic [PC_W-1:0] redir_pc,
  output logic [NYNG-1:0] squash_mask,
  output logic            flag_gt,
  output logic            flag_eq
);
  logic            is_cmp, is_ctl, taken;
  logic [DW-1:0]   res_d;
  logic [PC_W-1:0] tgt_d;
  logic            cmp_en, ctl_en;

  assign cmp_en = ex_valid && is_cmp;
  assign ctl_en = ex_valid && is_ctl;

  brc_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en),
    .opa(ex_opa), .opb(ex_opb), .gt_q(flag_gt), .eq_q(flag_eq)
  );

  brc_target #(.DW(DW), .PC_W(PC_W)) u_target (
    .op(ex_op), .pc(ex_pc), .opa(ex_opa), .ofs(ex_ofs),
    .gt(flag_gt), .eq(flag_eq), .uf(alu_uf), .ovf(alu_of),
    .is_cmp(is_cmp), .is_ctl(is_ctl), .taken(taken),
    .res(res_d), .tgt(tgt_d)
  );

  brc_redirect #(.DW(DW), .PC_W(PC_W), .NYNG(NYNG)) u_redir (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .taken(taken),
    .res_d(res_d), .tgt_d(tgt_d), .yng(yng_vld),
    .res_vld_q(res_vld), .res_q(res), .redir_q(redir),
    .tgt_q(redir_pc), .mask_q(squash_mask)
  );

  assert_redir_has_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir |-> res_vld);

  assert_idle_no_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |=> (!redir && !res_vld));

  assert_not_taken_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !redir && ($past(ex_op) != 4'd4)) |-> (res == '1));
endmodule

// File: tb/sim_brc_unit.sv
`timescale 1ns/1ps
module sim_brc_unit;
  localparam int DW = 32;
  localparam int PW = 10;
  localparam int NY = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ex_valid;
  logic [3:0]    ex_op;
  logic [PW-1:0] ex_pc;
  logic [DW-1:0] ex_opa, ex_opb, ex_ofs;
  logic          alu_uf, alu_of;
  logic [NY-1:0] yng_vld;
  logic          res_vld, redir, flag_gt, flag_eq;
  logic [DW-1:0] res;
  logic [PW-1:0] redir_pc;
  logic [NY-1:0] squash_mask;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  brc_unit u0 (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_op(ex_op),
    .ex_pc(ex_pc), .ex_opa(ex_opa), .ex_opb(ex_opb), .ex_ofs(ex_ofs),
    .alu_uf(alu_uf), .alu_of(alu_of), .yng_vld(yng_vld),
    .res_vld(res_vld), .res(res), .redir(redir), .redir_pc(redir_pc),
    .squash_mask(squash_mask), .flag_gt(flag_gt), .flag_eq(flag_eq)
  );

  typedef struct packed {
    logic [3:0]    op;
    logic [PW-1:0] pc;
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic [DW-1:0] ofs;
    logic          uf;
    logic          ovf;
    logic [NY-1:0] yng;
    logic          e_rv;
    logic [DW-1:0] e_res;
    logic          e_rd;
    logic [PW-1:0] e_tgt;
    logic [NY-1:0] e_sq;
    logic          e_gt;
    logic          e_eq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd1, 10'd0,    32'd1,          32'd0,          32'd0,          1'b0, 1'b0, 2'b00, 1'b0, 32'd0,          1'b0, 10'd0,    2'b00, 1'b1, 1'b0},
    '{4'd6, 10'd8,    32'd0,          32'd0,          32'hFFFFFFF9,   1'b0, 1'b0, 2'b11, 1'b1, 32'd1,          1'b1, 10'd1,    2'b11, 1'b1, 1'b0},
    '{4'd5, 10'd8,    32'd0,          32'd0,          32'd4,          1'b0, 1'b0, 2'b11, 1'b1, 32'hFFFFFFFF,   1'b0, 10'd0,    2'b00, 1'b1, 1'b0},
    '{4'd1, 10'd0,    32'hFFFFFFFB,   32'd3,          32'd0,          1'b0, 1'b0, 2'b00, 1'b0, 32'd0,          1'b0, 10'd0,    2'b00, 1'b0, 1'b0},
    '{4'd6, 10'd20,   32'd0,          32'd0,          32'd5,          1'b0, 1'b0, 2'b11, 1'b1, 32'hFFFFFFFF,   1'b0, 10'd0,    2'b00, 1'b0, 1'b0},
    '{4'd1, 10'd0,    32'd7,          32'd7,          32'd0,          1'b0, 1'b0, 2'b00, 1'b0, 32'd0,          1'b0, 10'd0,    2'b00, 1'b0, 1'b1},
    '{4'd5, 10'd1020, 32'd0,          32'd0,          32'd10,         1'b0, 1'b0, 2'b01, 1'b1, 32'd6,          1'b1, 10'd6,    2'b01, 1'b0, 1'b1},
    '{4'd7, 10'd3,    32'd0,          32'd0,          32'd2,          1'b1, 1'b0, 2'b10, 1'b1, 32'd5,          1'b1, 10'd5,    2'b10, 1'b0, 1'b1},
    '{4'd8, 10'd3,    32'd0,          32'd0,          32'd2,          1'b1, 1'b0, 2'b11, 1'b1, 32'hFFFFFFFF,   1'b0, 10'd0,    2'b00, 1'b0, 1'b1},
    '{4'd4, 10'd7,    32'd0,          32'd0,          32'd7,          1'b0, 1'b0, 2'b00, 1'b1, 32'd14,         1'b1, 10'd14,   2'b00, 1'b0, 1'b1},
    '{4'd2, 10'd0,    32'h200,        32'd0,          32'd3,          1'b0, 1'b0, 2'b11, 1'b1, 32'h203,        1'b1, 10'h203,  2'b11, 1'b0, 1'b1},
    '{4'd3, 10'd0,    32'h3FF,        32'd0,          32'd2,          1'b0, 1'b0, 2'b00, 1'b1, 32'h401,        1'b1, 10'd1,    2'b00, 1'b0, 1'b1},
    '{4'd4, 10'd2,    32'd0,          32'd0,          32'hFFFFFFFB,   1'b0, 1'b0, 2'b11, 1'b1, 32'hFFFFFFFD,   1'b1, 10'd1021, 2'b11, 1'b0, 1'b1},
    '{4'd15,10'd5,    32'd9,          32'd1,          32'd4,          1'b1, 1'b1, 2'b11, 1'b0, 32'd0,          1'b0, 10'd0,    2'b00, 1'b0, 1'b1},
    '{4'd1, 10'd0,    32'h80000000,   32'h7FFFFFFF,   32'd0,          1'b0, 1'b0, 2'b00, 1'b0, 32'd0,          1'b0, 10'd0,    2'b00, 1'b0, 1'b0},
    '{4'd8, 10'd0,    32'd0,          32'd0,          32'd0,          1'b0, 1'b1, 2'b11, 1'b1, 32'd0,          1'b1, 10'd0,    2'b11, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [PW-1:0] pc,
                       input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] o,
                       input logic u, input logic f, input logic [NY-1:0] y);
    ex_valid = v; ex_op = op; ex_pc = pc; ex_opa = a; ex_opb = b; ex_ofs = o;
    alu_uf = u; alu_of = f; yng_vld = y;
  endtask

  task automatic idle();
    drive(1'b0, 4'd0, '0, '0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R1 res_vld", {31'd0, res_vld}, 32'd0);
    check("R1 redir", {31'd0, redir}, 32'd0);
    check("R1 flags", {30'd0, flag_gt, flag_eq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 squash_mask after release", {30'd0, squash_mask}, 32'd0);

    // Table: one instruction per cycle, results checked one cycle later (R9)
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].op, VECS[i].pc, VECS[i].opa, VECS[i].opb, VECS[i].ofs,
            VECS[i].uf, VECS[i].ovf, VECS[i].yng);
      @(negedge clk);
      check("R9 R11 res_vld", {31'd0, res_vld}, {31'd0, VECS[i].e_rv});
      if (VECS[i].e_rv)
        check("R4 R5 R6 R7 R12 res", res, VECS[i].e_res);
      check("R4 R5 R6 R7 redir", {31'd0, redir}, {31'd0, VECS[i].e_rd});
      if (VECS[i].e_rd)
        check("R8 R12 redir_pc", {22'd0, redir_pc}, {22'd0, VECS[i].e_tgt});
      check("R10 squash_mask", {30'd0, squash_mask}, {30'd0, VECS[i].e_sq});
      check("R2 R3 flags", {30'd0, flag_gt, flag_eq}, {30'd0, VECS[i].e_gt, VECS[i].e_eq});
    end

    // R11: an invalid compare leaves the flags alone, an invalid branch is ignored
    drive(1'b1, 4'd1, '0, 32'd5, 32'd1, '0, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R2 gt set", {31'd0, flag_gt}, 32'd1);
    drive(1'b0, 4'd1, '0, 32'd0, 32'd0, '0, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R11 flags unchanged", {30'd0, flag_gt, flag_eq}, 32'd2);
    drive(1'b0, 4'd6, 10'd4, '0, '0, 32'd1, 1'b0, 1'b0, 2'b11);
    @(negedge clk);
    check("R11 no redirect", {31'd0, redir}, 32'd0);
    check("R11 no result", {31'd0, res_vld}, 32'd0);
    check("R11 no squash", {30'd0, squash_mask}, 32'd0);

    // R9: the strobe lasts exactly one cycle
    drive(1'b1, 4'd6, 10'd4, '0, '0, 32'd1, 1'b0, 1'b0, 2'b11);
    @(negedge clk);
    check("R9 strobe high", {31'd0, redir}, 32'd1);
    check("R10 mask high", {30'd0, squash_mask}, 32'd3);
    idle();
    @(negedge clk);
    check("R9 strobe low", {31'd0, redir}, 32'd0);
    check("R9 mask low", {30'd0, squash_mask}, 32'd0);

    // R1: reset in mid-run clears the flags
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 flags cleared", {30'd0, flag_gt, flag_eq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule